// File: doc/BRIEF.md
# UART Transmitter with CTS Hold-Off

This block turns buffered characters into asynchronous serial frames on a single output line. A producer writes characters through a push port. In queue mode the port feeds a 16-entry first-in first-out store. In single mode only one character can wait, which gives the classic pair of a holding register and a shift register. A separate frame engine takes the oldest waiting character and sends it. The frame is a low start bit, then 5 to 8 data bits starting with the least significant, then an optional parity bit, then a high stop period.

All timing comes from a one-cycle tick input that pulses at sixteen times the baud rate. When auto hold-off is enabled, a new character is taken only while the clear-to-send input is high. A character that has already started always runs to the end of its stop period. A break control forces the line low whatever the engine is doing. A status output shows when nothing is queued and nothing is being shifted.

Top module: `uart_tx_cts`

## Requirements
- R1: After a synchronous reset, `txd` is 1, `tx_idle` is 1, `wr_empty` is 1 and `wr_full` is 0.
- R2: A frame is one start bit at 0, then the data bits starting with the least significant. The data length is `word_len`+5: 0 gives 5 bits, 1 gives 6, 2 gives 7 and 3 gives 8. Data bits above that length are not sent. Between frames the line is 1.
- R3: When `par_en` is 1, one parity bit follows the data. When `par_odd` is 0, the data bits plus the parity bit hold an even number of ones. When `par_odd` is 1 they hold an odd number. When `par_en` is 0, no parity bit is sent.
- R4: With `stop_long`=0 the stop period is 16 ticks. With `stop_long`=1 it is 24 ticks for 5-bit characters and 32 ticks for longer ones. The stop level is 1.
- R5: Start, data and parity bits each last exactly 16 ticks. A whole frame therefore lasts 16*(1+data bits+parity bits) ticks plus the stop period.
- R6: With `fifo_en`=1 up to 16 characters are queued and sent in write order. `wr_full` is 1 when 16 characters are waiting, and a write made while `wr_full` is 1 is dropped.
- R7: With `fifo_en`=0 only one character waits. `wr_full` rises after one write. While the shifter is busy, a second character can be written once the first has moved into the shifter.
- R8: With `auto_cts`=1, no new frame starts while `cts` is 0, and waiting characters stay queued. With `auto_cts`=0, `cts` has no effect.
- R9: If `cts` falls during a frame, that frame still completes with its full length.
- R10: While `brk` is 1, `txd` is 0. When `brk` returns to 0 on an idle line, `txd` returns to 1.
- R11: `tx_idle` is 1 only when no character waits and no frame is in progress. It is 0 during the last frame even after the queue has drained.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick16 | input | 1 | One-cycle pulse at 16x the bit rate |
| fifo_en | input | 1 | 1: 16-entry queue, 0: single waiting character |
| wr_valid | input | 1 | Write strobe for a character |
| wr_data | input | 8 | Character to send |
| wr_full | output | 1 | No room for another character |
| wr_empty | output | 1 | No character waiting |
| word_len | input | 2 | Data length code, length = code + 5 |
| par_en | input | 1 | Append a parity bit |
| par_odd | input | 1 | 1: odd parity, 0: even parity |
| stop_long | input | 1 | Long stop period (24 or 32 ticks) |
| brk | input | 1 | Force the line low |
| auto_cts | input | 1 | Enable hold-off of new frames by `cts` |
| cts | input | 1 | Clear to send, active high |
| txd | output | 1 | Serial output, idles high |
| tx_idle | output | 1 | Queue and shifter both empty |

## Verification
A corrupted bit index or tick counter shows up as a wrong data bit or a frame of the wrong length on `txd`. It becomes visible within that same frame, at most 192 ticks after its start bit. A broken queue pointer shows within one frame as a dropped, repeated or reordered character when 16 characters are drained back to back. An error in the hold-off gate shows within a tick or two: either a start bit appears while `cts` is low, or the line stays idle after `cts` returns. Frame timing is checked by sampling every bit at its mid-point tick and by counting ticks from the start edge until `tx_idle`.

// File: rtl/utx_pkg.sv
package utx_pkg;

    localparam int CHAR_W        = 8;
    localparam int TICKS_PER_BIT = 16;
    localparam int TCNT_W        = $clog2(2 * TICKS_PER_BIT + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_DATA,
        ST_PAR,
        ST_STOP
    } tx_state_e;

    typedef struct packed {
        logic [1:0] len;
        logic       par_en;
        logic       par_odd;
        logic       stop_long;
    } frame_cfg_t;

    // Ticks in the stop period: 16, 24 (5-bit long stop) or 32.
    function automatic logic [TCNT_W-1:0] stop_ticks(input frame_cfg_t c);
        if (!c.stop_long)
            return TCNT_W'(TICKS_PER_BIT);
        else if (c.len == 2'd0)
            return TCNT_W'(TICKS_PER_BIT + TICKS_PER_BIT / 2);
        else
            return TCNT_W'(2 * TICKS_PER_BIT);
    endfunction

    // Parity over the bits that are actually sent.
    function automatic logic calc_parity(input logic [CHAR_W-1:0] d,
                                         input frame_cfg_t c);
        logic [CHAR_W-1:0] mask;
        mask = 8'hFF >> (2'd3 - c.len);
        return (^(d & mask)) ^ c.par_odd;
    endfunction

endpackage

// File: rtl/utx_fifo.sv
module utx_fifo
    import utx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              fifo_en,
    input  logic              push,
    input  logic [CHAR_W-1:0] wdata,
    input  logic              pop,
    output logic [CHAR_W-1:0] rdata,
    output logic              full,
    output logic              empty
);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic [CHAR_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic [CNT_W-1:0]  limit;
    logic              do_push, do_pop;

    assign limit   = fifo_en ? CNT_W'(DEPTH) : CNT_W'(1);
    assign full    = (count >= limit);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign rdata   = mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (do_push)
            mem[wr_ptr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push)
                wr_ptr <= (wr_ptr == PTR_W'(DEPTH - 1)) ? '0 : wr_ptr + 1'b1;
            if (do_pop)
                rd_ptr <= (rd_ptr == PTR_W'(DEPTH - 1)) ? '0 : rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // R6: occupancy never exceeds the storage size
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        count <= CNT_W'(DEPTH));

    // R6: a write into a full store without a read leaves the occupancy unchanged
    a_r6_full_drop: assert property (@(posedge clk) disable iff (rst)
        (full && push && !pop) |=> $stable(count));

endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
    import utx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              load,
    input  logic [CHAR_W-1:0] ld_data,
    input  frame_cfg_t        cfg,
    output logic              busy,
    output logic              line
);
    tx_state_e         state;
    frame_cfg_t        cfg_q;
    logic [CHAR_W-1:0] shreg;
    logic              par_q;
    logic [TCNT_W-1:0] tcnt;
    logic [TCNT_W-1:0] last_cnt;
    logic [2:0]        bidx;
    logic [2:0]        last_bit;
    logic              bit_end;

    assign last_cnt = (state == ST_STOP) ? stop_ticks(cfg_q) - 1'b1
                                         : TCNT_W'(TICKS_PER_BIT - 1);
    assign last_bit = 3'd4 + {1'b0, cfg_q.len};
    assign bit_end  = tick && (tcnt == last_cnt);
    assign busy     = (state != ST_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            shreg <= '0;
            par_q <= 1'b0;
            tcnt  <= '0;
            bidx  <= '0;
        end else if (state == ST_IDLE) begin
            if (load) begin
                state <= ST_START;
                cfg_q <= cfg;
                shreg <= ld_data;
                par_q <= calc_parity(ld_data, cfg);
                tcnt  <= '0;
                bidx  <= '0;
            end
        end else if (tick) begin
            if (tcnt == last_cnt) begin
                tcnt <= '0;
                case (state)
                    ST_START: state <= ST_DATA;
                    ST_DATA: begin
                        shreg <= shreg >> 1;
                        if (bidx == last_bit)
                            state <= cfg_q.par_en ? ST_PAR : ST_STOP;
                        else
                            bidx <= bidx + 1'b1;
                    end
                    ST_PAR:  state <= ST_STOP;
                    default: state <= ST_IDLE;
                endcase
            end else begin
                tcnt <= tcnt + 1'b1;
            end
        end
    end

    always_comb begin
        case (state)
            ST_START: line = 1'b0;
            ST_DATA:  line = shreg[0];
            ST_PAR:   line = par_q;
            default:  line = 1'b1;
        endcase
    end

    // R9: once started, a frame leaves the busy states only at the end of its stop period
    a_r9_frame_runs_out: assert property (@(posedge clk) disable iff (rst)
        (busy && !((state == ST_STOP) && bit_end)) |=> busy);

    // R4: the tick counter stays within the current bit's window
    a_r4_tick_window: assert property (@(posedge clk) disable iff (rst)
        busy |-> (tcnt <= last_cnt));

    // R2: a frame always begins with the start bit
    a_r2_start_first: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (state == ST_START));

endmodule

// File: rtl/uart_tx_cts.sv
module uart_tx_cts
    import utx_pkg::*;
#(
    parameter int DEPTH = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick16,
    input  logic              fifo_en,
    input  logic              wr_valid,
    input  logic [CHAR_W-1:0] wr_data,
    output logic              wr_full,
    output logic              wr_empty,
    input  logic [1:0]        word_len,
    input  logic              par_en,
    input  logic              par_odd,
    input  logic              stop_long,
    input  logic              brk,
    input  logic              auto_cts,
    input  logic              cts,
    output logic              txd,
    output logic              tx_idle
);
    logic [CHAR_W-1:0] head;
    logic              sh_busy;
    logic              sh_line;
    logic              start_ok;
    logic              take;
    frame_cfg_t        cfg;

    assign cfg      = '{len: word_len, par_en: par_en, par_odd: par_odd,
                        stop_long: stop_long};
    assign start_ok = !auto_cts || cts;
    assign take     = !sh_busy && !wr_empty && start_ok;

    utx_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk     (clk),
        .rst     (rst),
        .fifo_en (fifo_en),
        .push    (wr_valid),
        .wdata   (wr_data),
        .pop     (take),
        .rdata   (head),
        .full    (wr_full),
        .empty   (wr_empty)
    );

    utx_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick16),
        .load    (take),
        .ld_data (head),
        .cfg     (cfg),
        .busy    (sh_busy),
        .line    (sh_line)
    );

    assign txd     = brk ? 1'b0 : sh_line;
    assign tx_idle = wr_empty && !sh_busy;

    // R8: with hold-off enabled and clear-to-send low, an idle shifter stays idle
    a_r8_cts_hold: assert property (@(posedge clk) disable iff (rst)
        (auto_cts && !cts && !sh_busy) |=> !sh_busy);

    // R11: a character that is waiting never goes unnoticed by the idle status
    a_r11_idle_needs_empty: assert property (@(posedge clk) disable iff (rst)
        (wr_valid && !wr_full) |=> !tx_idle);

endmodule

// File: tb/sim_uart_tx_cts.sv
module sim_uart_tx_cts;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick16;
    logic       fifo_en = 1'b1;
    logic       wr_valid = 1'b0;
    logic [7:0] wr_data = '0;
    logic       wr_full, wr_empty;
    logic [1:0] word_len = 2'd3;
    logic       par_en = 1'b0, par_odd = 1'b0, stop_long = 1'b0;
    logic       brk = 1'b0, auto_cts = 1'b0, cts = 1'b1;
    logic       txd, tx_idle;

    int n_checks = 0;
    int n_fails  = 0;
    int cycles   = 0;
    logic [1:0] tdiv = '0;

    always #5 clk = ~clk;

    always @(posedge clk) tdiv <= tdiv + 1'b1;
    assign tick16 = (tdiv == 2'd3);

    uart_tx_cts u0 (
        .clk(clk), .rst(rst), .tick16(tick16), .fifo_en(fifo_en),
        .wr_valid(wr_valid), .wr_data(wr_data), .wr_full(wr_full),
        .wr_empty(wr_empty), .word_len(word_len), .par_en(par_en),
        .par_odd(par_odd), .stop_long(stop_long), .brk(brk),
        .auto_cts(auto_cts), .cts(cts), .txd(txd), .tx_idle(tx_idle)
    );

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: act=%0d exp=<150000 cycles", cycles);
            summary();
        end
    end

    task automatic check(input logic ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    // stimulus: {len, par_en, par_odd, stop_long, data}
    localparam logic [12:0] VEC [8] = '{
        {2'd3, 1'b0, 1'b0, 1'b0, 8'hA5},
        {2'd3, 1'b1, 1'b0, 1'b1, 8'h3C},
        {2'd3, 1'b1, 1'b1, 1'b0, 8'h81},
        {2'd0, 1'b0, 1'b0, 1'b1, 8'h1B},
        {2'd0, 1'b1, 1'b1, 1'b1, 8'hF7},
        {2'd1, 1'b1, 1'b0, 1'b1, 8'h2D},
        {2'd2, 1'b0, 1'b0, 1'b0, 8'h7F},
        {2'd2, 1'b1, 1'b1, 1'b1, 8'h00}
    };

    function automatic int exp_ticks(input int nb, input logic pe, input logic sl);
        int st;
        st = !sl ? 16 : (nb == 5 ? 24 : 32);
        return 16 * (1 + nb + (pe ? 1 : 0)) + st;
    endfunction

    function automatic logic exp_par(input logic [7:0] d, input int nb, input logic odd);
        logic p;
        p = odd;
        for (int i = 0; i < nb; i++) p ^= d[i];
        return p;
    endfunction

    task automatic push(input logic [7:0] d);
        @(negedge clk);
        wr_valid = 1'b1;
        wr_data  = d;
        @(negedge clk);
        wr_valid = 1'b0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Records mid-bit samples from the start edge; stops at tx_idle (stop_at==0) or after stop_at ticks.
    task automatic capture(input int stop_at, output logic [15:0] bits, output int nt);
        int w;
        w = 0;
        bits = '1;
        nt = 0;
        @(negedge clk);
        while (txd !== 1'b0 && w < 4000) begin
            @(negedge clk);
            w++;
        end
        if (w >= 4000) begin
            check(1'b0, "R2 start bit seen", 0, 1);
            return;
        end
        w = 0;
        while (w < 4000) begin
            if (stop_at == 0 && tx_idle) break;
            if (stop_at > 0 && nt >= stop_at) break;
            if (tick16) begin
                if ((nt % 16) == 8 && (nt / 16) < 16) bits[nt / 16] = txd;
                nt++;
            end
            @(negedge clk);
            w++;
        end
    endtask

    task automatic check_data(input logic [15:0] bits, input logic [7:0] d, input int nb, input string req);
        logic [7:0] got;
        got = '0;
        for (int i = 0; i < nb; i++) got[i] = bits[1 + i];
        check(got == (d & (8'hFF >> (8 - nb))) && bits[0] == 1'b0, req, int'(got), int'(d & (8'hFF >> (8 - nb))));
    endtask

    initial begin
        logic [15:0] bits;
        int nt;
        int nb;
        int idle_ok;
        logic [7:0] d;

        wait_cycles(3);
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(txd == 1'b1, "R1 txd idle high", txd, 1);
        check(tx_idle == 1'b1, "R1 tx_idle", tx_idle, 1);
        check(wr_empty == 1'b1 && wr_full == 1'b0, "R1 flags", {wr_empty, wr_full}, 2);

        // Table walk: R2 data, R3 parity, R4/R5 frame length
        for (int v = 0; v < 8; v++) begin
            word_len  = VEC[v][12:11];
            par_en    = VEC[v][10];
            par_odd   = VEC[v][9];
            stop_long = VEC[v][8];
            d         = VEC[v][7:0];
            nb        = 5 + int'(word_len);
            push(d);
            capture(0, bits, nt);
            check_data(bits, d, nb, "R2 data LSB first");
            if (par_en)
                check(bits[1 + nb] == exp_par(d, nb, par_odd), "R3 parity bit",
                      bits[1 + nb], exp_par(d, nb, par_odd));
            check(bits[1 + nb + (par_en ? 1 : 0)] == 1'b1, "R4 stop level", bits[1 + nb + (par_en ? 1 : 0)], 1);
            check(nt == exp_ticks(nb, par_en, stop_long), "R5 R4 frame ticks", nt, exp_ticks(nb, par_en, stop_long));
            check(txd == 1'b1, "R2 line idles high", txd, 1);
        end

        // R6 + R8: fill 17 while held off, 17th dropped, order kept
        word_len = 2'd3; par_en = 1'b0; par_odd = 1'b0; stop_long = 1'b0;
        auto_cts = 1'b1; cts = 1'b0;
        @(negedge clk);
        for (int i = 0; i < 17; i++) begin
            wr_valid = 1'b1;
            wr_data  = 8'h40 + 8'(i);
            @(negedge clk);
        end
        wr_valid = 1'b0;
        wait_cycles(200);
        check(wr_full == 1'b1, "R6 full after 16", wr_full, 1);
        check(txd == 1'b1 && tx_idle == 1'b0, "R8 no start while cts low", txd, 1);
        cts = 1'b1;
        for (int i = 0; i < 16; i++) begin
            capture(160, bits, nt);
            check_data(bits, 8'h40 + 8'(i), 8, "R6 queue order");
        end
        wait_cycles(40);
        check(tx_idle == 1'b1 && wr_empty == 1'b1, "R6 17th write dropped", tx_idle, 1);

        // R9: cts falls mid-frame; frame completes, next held
        push(8'h5A);
        push(8'hC3);
        fork
            capture(0 + 160, bits, nt);
            begin
                wait_cycles(200);
                cts = 1'b0;
            end
        join
        check_data(bits, 8'h5A, 8, "R9 frame completes after cts drop");
        check(nt == 160, "R9 full length", nt, 160);
        idle_ok = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) idle_ok = 0;
        end
        check(idle_ok == 1 && wr_empty == 1'b0, "R8 second char held", idle_ok, 1);
        cts = 1'b1;
        capture(0, bits, nt);
        check_data(bits, 8'hC3, 8, "R8 resumes after cts");

        // R8: cts ignored when hold-off disabled; R11 busy while queue empty
        auto_cts = 1'b0; cts = 1'b0;
        push(8'h96);
        wait_cycles(6);
        check(wr_empty == 1'b1 && tx_idle == 1'b0, "R11 busy with empty queue", tx_idle, 0);
        while (!tx_idle) @(negedge clk);
        check(txd == 1'b1, "R8 cts ignored frame finished", txd, 1);
        cts = 1'b1;

        // R7: single mode, held off: one waiting character only
        fifo_en = 1'b0; auto_cts = 1'b1; cts = 1'b0;
        push(8'h11);
        check(wr_full == 1'b1, "R7 full after one", wr_full, 1);
        push(8'h22);
        cts = 1'b1;
        capture(0, bits, nt);
        check_data(bits, 8'h11, 8, "R7 first char sent");
        idle_ok = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (txd !== 1'b1) idle_ok = 0;
        end
        check(idle_ok == 1, "R7 second write dropped", idle_ok, 1);

        // R7: hold plus shift: second char accepted once first is shifting
        push(8'h33);
        wait_cycles(8);
        check(wr_full == 1'b0, "R7 holding freed", wr_full, 0);
        push(8'h44);
        capture(160, bits, nt);
        check_data(bits, 8'h33, 8, "R7 first of pair");
        capture(0, bits, nt);
        check_data(bits, 8'h44, 8, "R7 second of pair");
        fifo_en = 1'b1;

        // R10: break
        @(negedge clk) brk = 1'b1;
        @(negedge clk);
        check(txd == 1'b0, "R10 break low", txd, 0);
        brk = 1'b0;
        @(negedge clk);
        check(txd == 1'b1, "R10 release high", txd, 1);

        summary();
    end

endmodule